// File: doc/BRIEF.md
# Status-register flash program/erase sequencer

This block runs write-side operations on a parallel NOR-style flash that reports progress through a status register. A client hands it one request at a time: single-word program, block erase or buffered program. The request carries an address, a data word and, for buffered programs, a word count. The sequencer then owns the flash bus until the operation ends. It issues the command writes, polls the status word until the device reports ready or a client-set poll limit runs out, and classifies the status into a result code. It leaves the device in read-array mode, and the result is presented together with a single-cycle completion pulse.

Before it programs anything, the block reads back the target words. It refuses the operation when a new word would need a bit to go from 0 to 1, because erasing is the only way to set bits. Buffered data is not passed on the request. The block asks for each word by index, and a client-side buffer answers in the same cycle. It asks once during the pre-check and once during the transfer.

The flash read path has one cycle of latency: a word requested with the read strobe is expected on the read-data input in the following cycle. Every command is a write with the command byte in bits 7:0 and zeros above.

Top module: `flash_seq`

## Requirements
- R1: After reset, done, the write strobe and the read strobe are low. The request is acknowledged in the same cycle only while the block is idle. The write strobe and the read strobe are never high in the same cycle.
- R2: Every operation that reaches the flash starts with a write of 0x50 (clear status) to the request address.
- R3: A single-word program (op 0) writes 0x50, 0x40 and then the data word, all to the request address. It then polls status there and finishes with a write of 0xFF.
- R4: A block erase (op 1) writes 0x50, 0x20 and 0xD0 to the request address, polls, and finishes with 0xFF.
- R5: A buffered program (op 2) of N words follows this sequence:
  - writes 0x50, then 0xE8 to the request address, and polls until ready;
  - writes N-1 to the request address;
  - writes the N words from buffer indices 0..N-1 to consecutive addresses starting at the request address;
  - writes 0xD0, polls again, and then writes 0x50 and 0xFF.
- R6: For op 0, and for every word of op 2, the current flash word ANDed with the new word must equal the new word. If any word fails this test, the result is 2 (not erased) and no write reaches the flash.
- R7: Op 3 is rejected with result 5 and no flash access. An op 2 request with N = 0 or N greater than the buffer depth is rejected the same way.
- R8: A ready status (bit 7 set) is classified in this priority order:
  - bit 1 gives 3 (protected);
  - otherwise bits 5 and 4 both set give 5 (sequence error);
  - otherwise bit 5 alone gives 4 (erase fail);
  - otherwise 0 (OK).
- R9: With poll limit L (L of 0 acts as 1), if L successive status reads all show bit 7 clear, the block writes 0xFF and reports 1 (timeout). A timeout in the first poll of a buffered program skips all remaining writes.
- R10: Done is high for exactly one cycle per accepted request, and result holds the code in that cycle.
- R11: Status bits 0, 2 and 6 have no effect on the result. Bit 4 alone or bit 3 (supply low) alone gives 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 program, 1 erase, 2 buffered program, 3 reserved |
| req_addr | input | AW | Target word address (block address for erase) |
| req_data | input | DW | Data word for single program |
| req_count | input | CW | Word count for buffered program |
| tmo_limit | input | TW | Maximum status reads per poll phase |
| req_ack | output | 1 | Request taken this cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with done |
| buf_idx | output | IW | Index of the buffered word wanted |
| buf_word | input | DW | Buffered word at buf_idx, same cycle |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe, data returned next cycle |
| fl_rdata | input | DW | Flash read data |

## Verification
Two things can land on the same status read: the ready bit appearing and the poll limit running out. The bench controls how many not-ready reads the flash model returns and pairs that with the limit. It drives busy counts equal to, one below and one above the limit, so that the last allowed read is either the ready one or the one that ends in timeout. The same applies to error bits: they are always present in the status word, so they must be ignored while the device is not ready and during the first poll of a buffered program. Each outcome is judged both by its result code and by the exact list of flash writes it produced.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_BUF   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_TIMEOUT    = 3'd1,
    RES_NOT_ERASED = 3'd2,
    RES_PROTECTED  = 3'd3,
    RES_ERASE_FAIL = 3'd4,
    RES_SEQ_ERR    = 3'd5
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK_RD, S_CHK_EV, S_CLR, S_CMD, S_ARG,
    S_BPOLL_RD, S_BPOLL_EV, S_BCNT, S_BDATA, S_BCONF,
    S_POLL_RD, S_POLL_EV, S_FCLR, S_RST
  } state_e;

  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_WORD_PGM = 8'h40;
  localparam logic [7:0] CMD_BLK_ERS  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_BUF_PGM  = 8'hE8;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;

endpackage

// File: rtl/fseq_status_decode.sv
module fseq_status_decode
  import fseq_pkg::*;
(
  input  logic [7:0] st,
  output logic [2:0] code
);
  logic unused_bits;
  assign unused_bits = ^{st[7], st[6], st[2], st[0]};

  always_comb begin
    if (st[1])                code = RES_PROTECTED;
    else if (st[5] && st[4])  code = RES_SEQ_ERR;
    else if (st[5])           code = RES_ERASE_FAIL;
    else if (st[4] || st[3])  code = RES_SEQ_ERR;
    else                      code = RES_OK;
  end
endmodule

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (cnt_q != '1)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = ({1'b0, cnt_q} + {{TW{1'b0}}, 1'b1}) >= {1'b0, limit};

  AST_NO_POLL_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && !clr && expired)); // R9
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import fseq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int TW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] req_count,
  input  logic [TW-1:0] tmo_limit,
  output logic          req_ack,
  output logic          done,
  output logic [2:0]    result,
  output logic [IW-1:0] buf_idx,
  input  logic [DW-1:0] buf_word,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [DW-1:0] fl_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  state_e        state_q, state_d;
  op_e           op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  res_e          res_q, res_d;
  logic          done_q, done_d;
  logic          tmr_clr, tmr_inc, tmr_expired;
  logic [2:0]    dec_code;
  logic [IW-1:0] last_idx;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] want;

  function automatic logic [DW-1:0] cmd(input logic [7:0] c);
    return {{(DW-8){1'b0}}, c};
  endfunction

  assign last_idx  = IW'(cnt_q - 1'b1);
  assign word_addr = addr_q + AW'(idx_q);
  assign want      = (op_q == OP_BUF) ? buf_word : data_q;

  fseq_poll_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_i), .clr(tmr_clr), .inc(tmr_inc),
    .limit(tmo_limit), .expired(tmr_expired)
  );

  fseq_status_decode u_decode (.st(fl_rdata[7:0]), .code(dec_code));

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    addr_d   = addr_q;
    data_d   = data_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    res_d    = res_q;
    done_d   = 1'b0;
    req_ack  = 1'b0;
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    fl_addr  = addr_q;
    fl_wdata = '0;
    tmr_clr  = 1'b0;
    tmr_inc  = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        req_ack = 1'b1;
        op_d    = op_e'(req_op);
        addr_d  = req_addr;
        data_d  = req_data;
        cnt_d   = req_count;
        idx_d   = '0;
        if (req_op == OP_RSVD ||
            (req_op == OP_BUF && (req_count == '0 || req_count > CW'(DEPTH)))) begin
          res_d  = RES_SEQ_ERR;
          done_d = 1'b1;
        end else if (req_op == OP_ERASE) state_d = S_CLR;
        else                             state_d = S_CHK_RD;
      end
      S_CHK_RD: begin
        fl_re   = 1'b1;
        fl_addr = word_addr;
        state_d = S_CHK_EV;
      end
      S_CHK_EV: begin
        if ((fl_rdata & want) != want) begin
          res_d   = RES_NOT_ERASED;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (op_q == OP_PROG || idx_q == last_idx) begin
          idx_d   = '0;
          state_d = S_CLR;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = S_CHK_RD;
        end
      end
      S_CLR: begin
        fl_we    = 1'b1;
        fl_wdata = cmd(CMD_CLR_STAT);
        state_d  = S_CMD;
      end
      S_CMD: begin
        fl_we = 1'b1;
        if (op_q == OP_BUF) begin
          fl_wdata = cmd(CMD_BUF_PGM);
          tmr_clr  = 1'b1;
          state_d  = S_BPOLL_RD;
        end else begin
          fl_wdata = (op_q == OP_ERASE) ? cmd(CMD_BLK_ERS) : cmd(CMD_WORD_PGM);
          state_d  = S_ARG;
        end
      end
      S_ARG: begin
        fl_we    = 1'b1;
        fl_wdata = (op_q == OP_ERASE) ? cmd(CMD_CONFIRM) : data_q;
        tmr_clr  = 1'b1;
        state_d  = S_POLL_RD;
      end
      S_BPOLL_RD: begin
        fl_re   = 1'b1;
        state_d = S_BPOLL_EV;
      end
      S_BPOLL_EV: begin
        if (fl_rdata[7]) state_d = S_BCNT;
        else if (tmr_expired) begin
          res_d   = RES_TIMEOUT;
          state_d = S_RST;
        end else begin
          tmr_inc = 1'b1;
          state_d = S_BPOLL_RD;
        end
      end
      S_BCNT: begin
        fl_we    = 1'b1;
        fl_wdata = DW'(cnt_q - 1'b1);
        idx_d    = '0;
        state_d  = S_BDATA;
      end
      S_BDATA: begin
        fl_we    = 1'b1;
        fl_addr  = word_addr;
        fl_wdata = buf_word;
        if (idx_q == last_idx) state_d = S_BCONF;
        else                   idx_d   = idx_q + 1'b1;
      end
      S_BCONF: begin
        fl_we    = 1'b1;
        fl_wdata = cmd(CMD_CONFIRM);
        tmr_clr  = 1'b1;
        state_d  = S_POLL_RD;
      end
      S_POLL_RD: begin
        fl_re   = 1'b1;
        state_d = S_POLL_EV;
      end
      S_POLL_EV: begin
        if (fl_rdata[7]) begin
          res_d   = res_e'(dec_code);
          state_d = (op_q == OP_BUF) ? S_FCLR : S_RST;
        end else if (tmr_expired) begin
          res_d   = RES_TIMEOUT;
          state_d = S_RST;
        end else begin
          tmr_inc = 1'b1;
          state_d = S_POLL_RD;
        end
      end
      S_FCLR: begin
        fl_we    = 1'b1;
        fl_wdata = cmd(CMD_CLR_STAT);
        state_d  = S_RST;
      end
      S_RST: begin
        fl_we    = 1'b1;
        fl_wdata = cmd(CMD_ARRAY);
        done_d   = 1'b1;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      res_q   <= RES_OK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      res_q   <= res_d;
      done_q  <= done_d;
    end
  end

  assign done    = done_q;
  assign result  = res_q;
  assign buf_idx = idx_q;

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i)
    !(fl_we && fl_re)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done); // R10
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == S_IDLE) |-> (!fl_we && !fl_re)); // R7
  AST_ENDS_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(done) && (result != 3'(RES_NOT_ERASED)) && (result != 3'(RES_SEQ_ERR) || $past(fl_we))
      |-> $past(fl_we) && ($past(fl_wdata) == cmd(CMD_ARRAY))); // R9
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    req_ack |-> (state_q == S_IDLE)); // R1
endmodule

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [7:0]  req_addr;
  logic [15:0] req_data;
  logic [4:0]  req_count;
  logic [15:0] tmo_limit;
  logic        req_ack, done;
  logic [2:0]  result;
  logic [3:0]  buf_idx;
  logic [15:0] buf_word;
  logic [7:0]  fl_addr;
  logic [15:0] fl_wdata;
  logic        fl_we, fl_re;
  logic [15:0] fl_rdata;

  always #4 clk = ~clk;

  flash_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_count(req_count),
    .tmo_limit(tmo_limit), .req_ack(req_ack), .done(done), .result(result),
    .buf_idx(buf_idx), .buf_word(buf_word), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  // flash model
  logic [15:0] mem [256];
  logic [15:0] bufw [16];
  logic [7:0]  la [64];
  logic [15:0] ld [64];
  int          ln = 0;
  int          rd_cnt = 0;
  int          busy_cfg = 0;
  logic [6:0]  inj = '0;
  bit          in_status = 1'b0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  assign buf_word = bufw[buf_idx];

  always @(posedge clk) begin
    if (fl_we) begin
      if (ln < 64) begin
        la[ln] = fl_addr;
        ld[ln] = fl_wdata;
      end
      ln++;
      rd_cnt = 0;
      in_status = (fl_wdata != 16'h00FF);
    end
    if (fl_re) begin
      if (in_status) begin
        fl_rdata <= {8'h00, (rd_cnt >= busy_cfg), inj};
        rd_cnt++;
      end else fl_rdata <= mem[fl_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int decode_exp(input logic [6:0] b);
    if (b[1])              return 3;
    if (b[5] && b[4])      return 5;
    if (b[5])              return 4;
    if (b[4] || b[3])      return 5;
    return 0;
  endfunction

  function automatic int exp_result(input int op, input logic [7:0] a, input logic [15:0] d,
                                    input int n, input int lim);
    if (op == 3) return 5;
    if (op == 2 && (n < 1 || n > 16)) return 5;
    if (op == 0 && ((mem[a] & d) != d)) return 2;
    if (op == 2)
      for (int i = 0; i < n; i++)
        if ((mem[8'(a + i)] & bufw[i]) != bufw[i]) return 2;
    if (busy_cfg >= lim) return 1;
    return decode_exp(inj);
  endfunction

  task automatic do_op(input int op, input logic [7:0] a, input logic [15:0] d,
                       input int n, input int lim, input string rtag);
    int er, k, en;
    logic [7:0]  ea [64];
    logic [15:0] ed [64];
    bit bad;
    string ltag;
    er = exp_result(op, a, d, n, lim);
    en = 0;
    if (er != 5 || (op != 3 && !(op == 2 && (n < 1 || n > 16)))) begin
      if (er != 2) begin
        ea[en] = a; ed[en] = 16'h0050; en++;
        if (op == 0) begin
          ea[en] = a; ed[en] = 16'h0040; en++;
          ea[en] = a; ed[en] = d;        en++;
        end else if (op == 1) begin
          ea[en] = a; ed[en] = 16'h0020; en++;
          ea[en] = a; ed[en] = 16'h00D0; en++;
        end else begin
          ea[en] = a; ed[en] = 16'h00E8; en++;
          if (er != 1) begin
            ea[en] = a; ed[en] = 16'(n - 1); en++;
            for (int i = 0; i < n; i++) begin
              ea[en] = 8'(a + i); ed[en] = bufw[i]; en++;
            end
            ea[en] = a; ed[en] = 16'h00D0; en++;
            ea[en] = a; ed[en] = 16'h0050; en++;
          end
        end
        ea[en] = a; ed[en] = 16'h00FF; en++;
      end
    end
    @(negedge clk);
    ln = 0;
    req_valid = 1'b1; req_op = op[1:0]; req_addr = a; req_data = d;
    req_count = n[4:0]; tmo_limit = lim[15:0];
    #1 chk(req_ack == 1'b1, "R1", 32'(req_ack), 1);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (done !== 1'b1 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(done === 1'b1, rtag, 32'(done), 1);
    chk(32'(result) == er, rtag, 32'(result), er);
    @(negedge clk);
    chk(done == 1'b0, "R10", 32'(done), 0);
    if (en == 0) ltag = (er == 2) ? "R6" : "R7";
    else ltag = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
    bad = (ln != en);
    for (int i = 0; i < en && !bad; i++)
      if (la[i] != ea[i] || ld[i] != ed[i]) begin
        bad = 1'b1;
        $display("  write %0d: addr %0h data %0h, wanted addr %0h data %0h", i, la[i], ld[i], ea[i], ed[i]);
      end
    chk(!bad, ltag, 32'(ln), 32'(en));
    if (en > 0) chk(ln > 0 && ld[0] == 16'h0050 && la[0] == a, "R2", 32'(ld[0]), 32'h50);
  endtask

  task automatic fill_buf(input logic [7:0] a, input int n, input bit fit);
    for (int i = 0; i < 16; i++) bufw[i] = 16'($urandom);
    if (fit) for (int i = 0; i < n; i++) bufw[i] = bufw[i] & mem[8'(a + i)];
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    req_count = '0; tmo_limit = 16'd4; fl_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    for (int i = 0; i < 16; i++) bufw[i] = '0;
    repeat (3) @(negedge clk);
    chk(done == 0 && fl_we == 0 && fl_re == 0, "R1", {done, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 0 && fl_we == 0 && fl_re == 0, "R1", {done, fl_we, fl_re}, 0);

    // R7 rejects
    busy_cfg = 0; inj = '0;
    do_op(2, 8'h10, 16'h0, 0, 4, "R7");
    do_op(2, 8'h10, 16'h0, 17, 4, "R7");
    do_op(3, 8'h20, 16'h1234, 1, 4, "R7");
    // R6 not erased
    mem[8'h30] = 16'h00F0;
    do_op(0, 8'h30, 16'h0F0F, 1, 4, "R6");
    mem[8'h43] = 16'h0000;
    fill_buf(8'h40, 4, 1'b0);
    bufw[0] = 16'h0; bufw[1] = 16'h0; bufw[2] = 16'h0; bufw[3] = 16'h0001;
    do_op(2, 8'h40, 16'h0, 4, 4, "R6");
    mem[8'h43] = 16'hFFFF;
    // basic sequences
    do_op(0, 8'h50, 16'hA5A5, 1, 4, "R3");
    do_op(1, 8'h60, 16'h0, 1, 4, "R4");
    fill_buf(8'hF8, 16, 1'b1);
    do_op(2, 8'hF8, 16'h0, 16, 4, "R5");
    fill_buf(8'h70, 1, 1'b1);
    do_op(2, 8'h70, 16'h0, 1, 4, "R5");
    // R9 timeout race: busy vs limit
    busy_cfg = 3; do_op(0, 8'h51, 16'h1111, 1, 3, "R9");
    busy_cfg = 2; do_op(0, 8'h52, 16'h2222, 1, 3, "R9");
    busy_cfg = 4; do_op(1, 8'h53, 16'h0, 1, 3, "R9");
    busy_cfg = 5; fill_buf(8'h80, 3, 1'b1); do_op(2, 8'h80, 16'h0, 3, 2, "R9");
    busy_cfg = 1; inj = 7'h30; fill_buf(8'h90, 2, 1'b1); do_op(2, 8'h90, 16'h0, 2, 2, "R8");
    // R8 priorities
    busy_cfg = 0;
    inj = 7'h30; do_op(1, 8'hA0, 16'h0, 1, 4, "R8");
    inj = 7'h32; do_op(1, 8'hA1, 16'h0, 1, 4, "R8");
    inj = 7'h20; do_op(1, 8'hA2, 16'h0, 1, 4, "R8");
    // R11 ignored / other bits
    inj = 7'h45; do_op(0, 8'hB0, 16'h0F00, 1, 4, "R11");
    inj = 7'h08; do_op(0, 8'hB1, 16'h00F0, 1, 4, "R11");
    inj = 7'h10; do_op(1, 8'hB2, 16'h0, 1, 4, "R11");

    // random mix
    for (int i = 0; i < 256; i++) mem[i] = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'hFFFF;
    for (int t = 0; t < 40; t++) begin
      int op, n, lim;
      logic [7:0] a;
      logic [15:0] d;
      op = $urandom_range(0, 2);
      a = 8'($urandom);
      d = 16'($urandom);
      if ($urandom_range(0, 4) != 0) d = d & mem[a];
      n = $urandom_range(1, 16);
      fill_buf(a, n, $urandom_range(0, 4) != 0);
      busy_cfg = $urandom_range(0, 5);
      lim = $urandom_range(1, 6);
      inj = ($urandom_range(0, 1) == 0) ? 7'h00 : 7'($urandom);
      do_op(op, a, d, n, lim, (op == 0) ? "R3" : (op == 1) ? "R4" : "R5");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule